// File: doc/BRIEF.md
# Interrupt Message Ring Writer

This block takes message-signalled interrupts and turns each one into a 16-byte record in a circular buffer in system memory. Each incoming message carries a 16-bit interrupt identifier. The block places that identifier, little-endian, in the first bytes of the record. It issues one 128-bit memory write per record on a request/ready port, at an address formed from a 64-bit base plus a byte offset. A single level-sensitive interrupt line tells the host that unread records are present.

Software sets up the block through a small word-addressed register file. It holds a control word, the two halves of the buffer base address, the software-owned read offset and the hardware-owned write offset. The buffer size is picked at run time as a power of two from 32 KB to 256 KB. When the buffer fills, a control bit selects between two policies: either new messages are discarded and a sticky overflow flag is raised, or the oldest record is overwritten. Incoming messages use a valid/ready handshake. One message can wait in a holding stage while the previous record's memory write is outstanding.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, `mem_req` is low and `msg_ready` is high.
- R2: Register word offsets: 0 control, 3 base high, 4 base low, 5 read offset, 6 write offset; every other offset reads zero. Writes to offset 6 have no effect. Control fields: bit 0 enable, bit 1 full detection, bit 3 interrupt enable, bit 4 stop-when-full, bits 9:8 size code, bit 15 sticky overflow. All other control bits read zero.
- R3: Each record write carries the 64-bit address {base high, base low} + write offset. Its data holds the message identifier in bits 15:0 (byte 0 in bits 7:0) and zero in bits 127:16.
- R4: A message accepted at clock edge k produces `mem_req` high after edge k+1. `mem_req`, `mem_addr` and `mem_data` then hold steady until the edge where `mem_ready` is also high.
- R5: On each completed record write, the write offset advances by 16 and wraps to zero at 2^(15+size code) bytes. It changes at no other time.
- R6: A write to the read offset register stores the value with its low four bits cleared, masked to below the configured buffer size.
- R7: `irq` is high exactly when interrupt enable is set and the read and write offsets differ.
- R8: The buffer is full when full detection is set and (write offset + 16) mod size equals the read offset. A message reaching the write stage while the buffer is full with stop-when-full set is discarded with no memory write. It also sets control bit 15, which stays set until a control write with bit 15 high clears it.
- R9: While the buffer is full and stop-when-full is clear, the record is written anyway and the read offset is pushed forward by 16. With full detection clear, the read offset is never moved by hardware.
- R10: While enable is clear, messages are accepted (`msg_ready` stays high) and discarded, with no memory write and no change to the offsets.
- R11: `msg_ready` is low while the holding stage is occupied. The holding stage drains only when no record write is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| msg_valid | input | 1 | Incoming interrupt message valid |
| msg_ready | output | 1 | Block can take a message |
| msg_data | input | 16 | Interrupt identifier |
| mem_req | output | 1 | Record write request |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents |
| irq | output | 1 | Level interrupt to the host |

## Verification
A message is accepted at one edge, moves to the write stage at the next edge, and `mem_req` is visible one edge after acceptance. Offsets, `irq` and the overflow flag change at the edge where the write completes or where the drop decision is made. All these results can therefore be read at the falling edge after that edge. The bench drives inputs and samples outputs on falling edges only. It inspects `mem_req` at the first and third falling edges after acceptance, reads offsets and flags through the register port only after the write pipeline has drained, and logs each record at the falling edge where its memory model raises `mem_ready`. Addresses and data are then compared against offsets computed arithmetically from the size code, with the base chosen so that the 64-bit add carries.

// File: rtl/msiw_pkg.sv
// Shared constants and types for the interrupt message ring writer.
// Assumes a 3-bit word-offset register address.
package msiw_pkg;

    // Register word offsets
    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_BASE_HI = 3'd3;
    localparam logic [2:0] A_BASE_LO = 3'd4;
    localparam logic [2:0] A_RD_OFF  = 3'd5;
    localparam logic [2:0] A_WR_OFF  = 3'd6;

    // Control word bit positions
    localparam int CB_EN      = 0;
    localparam int CB_FDET    = 1;
    localparam int CB_IRQEN   = 3;
    localparam int CB_STOP    = 4;
    localparam int CB_SIZE_LO = 8;
    localparam int CB_OVF     = 15;

    typedef struct packed {
        logic en;
        logic fdet;
        logic irqen;
        logic stop;
    } msiw_flags_t;

endpackage

// File: rtl/msiw_regs.sv
// Register file: control flags, size code, sticky overflow, base address,
// and the readback mux. The offsets themselves live in the ring engine.
// Assumes REG_W >= OFF_W and REG_W > CB_OVF.
module msiw_regs
    import msiw_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int SIZE_W = 2,
    parameter int OFF_W  = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 ovf_set,
    input  logic [OFF_W-1:0]     rd_off,
    input  logic [OFF_W-1:0]     wr_off,
    output msiw_flags_t          flags,
    output logic [SIZE_W-1:0]    size_code,
    output logic [2*REG_W-1:0]   base_addr,
    output logic                 sw_rd_we,
    output logic [OFF_W-1:0]     sw_rd_val,
    output logic                 ovf,
    output logic [REG_W-1:0]     reg_rdata
);

    logic [REG_W-1:0] base_hi, base_lo;
    logic             ctrl_we;

    assign ctrl_we   = reg_we && (reg_addr == A_CTRL);
    assign sw_rd_we  = reg_we && (reg_addr == A_RD_OFF);
    assign sw_rd_val = reg_wdata[OFF_W-1:0];
    assign base_addr = {base_hi, base_lo};

    // Control fields and base address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags     <= '0;
            size_code <= '0;
            base_hi   <= '0;
            base_lo   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    flags.en    <= reg_wdata[CB_EN];
                    flags.fdet  <= reg_wdata[CB_FDET];
                    flags.irqen <= reg_wdata[CB_IRQEN];
                    flags.stop  <= reg_wdata[CB_STOP];
                    size_code   <= reg_wdata[CB_SIZE_LO +: SIZE_W];
                end
                A_BASE_HI: base_hi <= reg_wdata;
                A_BASE_LO: base_lo <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Sticky overflow: a hardware set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (ovf_set)
            ovf <= 1'b1;
        else if (ctrl_we && reg_wdata[CB_OVF])
            ovf <= 1'b0;
    end

    // Readback mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CB_EN]                 = flags.en;
                reg_rdata[CB_FDET]               = flags.fdet;
                reg_rdata[CB_IRQEN]              = flags.irqen;
                reg_rdata[CB_STOP]               = flags.stop;
                reg_rdata[CB_SIZE_LO +: SIZE_W]  = size_code;
                reg_rdata[CB_OVF]                = ovf;
            end
            A_BASE_HI: reg_rdata = base_hi;
            A_BASE_LO: reg_rdata = base_lo;
            A_RD_OFF:  reg_rdata = REG_W'(rd_off);
            A_WR_OFF:  reg_rdata = REG_W'(wr_off);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/msiw_ring.sv
// Ring engine: one-deep holding stage, one outstanding record write, the
// read/write offsets, the size mask and the full-buffer policy.
// Assumes the write offset is only meaningful while the size code is
// unchanged; offsets are re-masked on every update.
module msiw_ring
    import msiw_pkg::*;
#(
    parameter int MIN_SHIFT = 15,
    parameter int SIZE_W    = 2,
    parameter int OFF_W     = 18,
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 128,
    parameter int ID_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  msiw_flags_t         flags,
    input  logic [SIZE_W-1:0]   size_code,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic                sw_rd_we,
    input  logic [OFF_W-1:0]    sw_rd_val,
    input  logic                msg_valid,
    input  logic [ID_W-1:0]     msg_id,
    output logic                msg_ready,
    output logic                mem_req,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_data,
    output logic [OFF_W-1:0]    rd_off,
    output logic [OFF_W-1:0]    wr_off,
    output logic                ovf_set
);

    localparam int               ENT_B = DATA_W / 8;
    localparam logic [OFF_W-1:0] ALIGN = ~OFF_W'(ENT_B - 1);
    localparam logic [OFF_W-1:0] STEP  = OFF_W'(ENT_B);

    logic [OFF_W-1:0] span_mask, size_mask, wr_next, rd_next;
    logic             hold_v;
    logic [ID_W-1:0]  hold_id, out_id;
    logic             full, accept, move, drop, done;

    // Size mask: 2^(MIN_SHIFT+code) bytes, entry aligned
    always_comb begin
        span_mask = (OFF_W'(1) << (MIN_SHIFT + int'(size_code))) - OFF_W'(1);
        size_mask = span_mask & ALIGN;
    end

    assign wr_next   = (wr_off + STEP) & size_mask;
    assign rd_next   = (rd_off + STEP) & size_mask;
    assign full      = flags.fdet && (wr_next == rd_off);
    assign msg_ready = !hold_v;
    assign accept    = msg_valid && msg_ready && flags.en;
    assign move      = hold_v && !mem_req;
    assign drop      = move && full && flags.stop;
    assign done      = mem_req && mem_ready;
    assign ovf_set   = drop;
    assign mem_data  = {{(DATA_W-ID_W){1'b0}}, out_id};

    // Holding stage: filled on accept, emptied when it moves on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v  <= 1'b0;
            hold_id <= '0;
        end else if (accept) begin
            hold_v  <= 1'b1;
            hold_id <= msg_id;
        end else if (move) begin
            hold_v  <= 1'b0;
        end
    end

    // Write stage: request held until the memory takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
            out_id   <= '0;
        end else if (move && !drop) begin
            mem_req  <= 1'b1;
            mem_addr <= base_addr + ADDR_W'(wr_off);
            out_id   <= hold_id;
        end else if (done) begin
            mem_req  <= 1'b0;
        end
    end

    // Write offset advances on each completed record
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_off <= '0;
        else if (done)
            wr_off <= wr_next;
    end

    // Read offset: software write, or pushed by an overwrite
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_off <= '0;
        else if (sw_rd_we)
            rd_off <= sw_rd_val & size_mask;
        else if (done && full && !flags.stop)
            rd_off <= rd_next;
    end

endmodule

// File: rtl/msi_ring_writer.sv
// Top: captures interrupt messages into a memory ring and raises a level
// interrupt while unread records exist. Assumes one memory write in flight.
module msi_ring_writer
    import msiw_pkg::*;
#(
    parameter int MIN_SHIFT = 15,
    parameter int SIZE_W    = 2,
    parameter int REG_W     = 32,
    parameter int DATA_W    = 128,
    parameter int ID_W      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 msg_valid,
    output logic                 msg_ready,
    input  logic [ID_W-1:0]      msg_data,
    output logic                 mem_req,
    input  logic                 mem_ready,
    output logic [2*REG_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]    mem_data,
    output logic                 irq
);

    localparam int ADDR_W = 2 * REG_W;
    localparam int OFF_W  = MIN_SHIFT + (1 << SIZE_W) - 1;

    msiw_flags_t         flags;
    logic [SIZE_W-1:0]   size_code;
    logic [ADDR_W-1:0]   base_addr;
    logic                sw_rd_we, ovf, ovf_set;
    logic [OFF_W-1:0]    sw_rd_val, rd_off, wr_off;

    msiw_regs #(.REG_W(REG_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ovf_set(ovf_set), .rd_off(rd_off),
        .wr_off(wr_off), .flags(flags), .size_code(size_code),
        .base_addr(base_addr), .sw_rd_we(sw_rd_we), .sw_rd_val(sw_rd_val),
        .ovf(ovf), .reg_rdata(reg_rdata)
    );

    msiw_ring #(.MIN_SHIFT(MIN_SHIFT), .SIZE_W(SIZE_W), .OFF_W(OFF_W),
                .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) i_ring (
        .clk(clk), .rst_n(rst_n), .flags(flags), .size_code(size_code),
        .base_addr(base_addr), .sw_rd_we(sw_rd_we), .sw_rd_val(sw_rd_val),
        .msg_valid(msg_valid), .msg_id(msg_data), .msg_ready(msg_ready),
        .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .rd_off(rd_off), .wr_off(wr_off),
        .ovf_set(ovf_set)
    );

    // Level interrupt while unread records exist
    assign irq = flags.irqen && (rd_off != wr_off);

endmodule

// File: rtl/msiw_chk.sv
// Protocol and state checks for msi_ring_writer, attached by bind.
module msiw_chk #(
    parameter int OFF_W  = 18,
    parameter int DATA_W = 128,
    parameter int ID_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_ready,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [63:0]       mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              irq,
    input logic              irq_en,
    input logic              stop_en,
    input logic              ovf,
    input logic [OFF_W-1:0]  rd_off,
    input logic [OFF_W-1:0]  wr_off
);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    // R3
    entry_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_data[DATA_W-1:ID_W] == '0);

    // R5
    wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off[3:0] == 4'd0);

    // R5
    wr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_off) |-> $past(mem_req) && $past(mem_ready));

    // R6
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_off[3:0] == 4'd0);

    // R7
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_off == wr_off) || !irq_en |-> !irq);

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(stop_en));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready && !msg_ready |=> !msg_ready);

endmodule

bind msi_ring_writer msiw_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W), .ID_W(ID_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .msg_ready(msg_ready), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .irq(irq), .irq_en(flags.irqen), .stop_en(flags.stop), .ovf(ovf),
    .rd_off(rd_off), .wr_off(wr_off)
);

// File: tb/test_msi_ring_writer.sv
// Self-checking bench: near-exhaustive ring sweeps over the two smallest
// sizes plus directed full-buffer, disable and back-pressure cases.
module test_msi_ring_writer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msg_valid = 1'b0;
    logic         msg_ready;
    logic [15:0]  msg_data = '0;
    logic         mem_req;
    logic         mem_ready = 1'b0;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         irq;

    int total = 0;
    int bad = 0;
    int lat = 0;
    int cnt = 0;
    logic [63:0]  cap_addr[$];
    logic [127:0] cap_data[$];

    localparam logic [63:0] BASE = 64'h0000_0001_FFFF_8000;

    always #2 clk = ~clk;

    msi_ring_writer i_msi_ring_writer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_data(msg_data), .mem_req(mem_req),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .irq(irq)
    );

    // Memory model: grants after lat falling edges, logs each record
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_ready = 1'b1;
                cap_addr.push_back(mem_addr);
                cap_data.push_back(mem_data);
            end else begin
                cnt++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [15:0] id);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = id;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (24) @(negedge clk);
    endtask

    function automatic logic [17:0] mask_of(input int code);
        return 18'(((1 << (15 + code)) - 1) & ~15);
    endfunction

    // Stream n messages back to back; check every record arithmetically
    task automatic sweep(input int n, input logic [17:0] start, input int code);
        int first = cap_addr.size();
        logic [17:0] off;
        lat = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            msg_valid = 1'b1; msg_data = 16'(i * 7 + 3);
            while (!msg_ready) @(negedge clk);
        end
        @(negedge clk);
        msg_valid = 1'b0;
        drain();
        chk("R5", "sweep record count", 128'(cap_addr.size() - first), 128'(n));
        for (int i = 0; i < n && first + i < cap_addr.size(); i++) begin
            off = (start + 18'(16 * i)) & mask_of(code);
            chk("R5", "sweep address", 128'(cap_addr[first + i]), 128'(BASE + 64'(off)));
            chk("R3", "sweep data", cap_data[first + i], 128'(16'(i * 7 + 3)));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "irq", 128'(irq), 0);
        chk("R1", "mem_req", 128'(mem_req), 0);
        chk("R1", "msg_ready", 128'(msg_ready), 1);
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), v);
            chk("R1", "register reset value", 128'(v), 0);
        end

        // R2: decode and readback
        wr_reg(3'd3, 32'h0000_0001);
        wr_reg(3'd4, 32'hFFFF_8000);
        wr_reg(3'd0, 32'hFFFF_7C0B);
        rd_reg(3'd0, v); chk("R2", "control readback", 128'(v), 128'h0000_000B);
        wr_reg(3'd0, 32'h0000_000B);
        rd_reg(3'd3, v); chk("R2", "base high", 128'(v), 128'h1);
        rd_reg(3'd4, v); chk("R2", "base low", 128'(v), 128'hFFFF_8000);
        for (int a = 1; a < 3; a++) begin
            wr_reg(3'(a), 32'h1234_5678);
            rd_reg(3'(a), v); chk("R2", "unused offset", 128'(v), 0);
        end
        rd_reg(3'd7, v); chk("R2", "unused offset 7", 128'(v), 0);
        wr_reg(3'd6, 32'h0000_0120);
        rd_reg(3'd6, v); chk("R2", "write offset ignores writes", 128'(v), 0);

        // R4, R3, R11: timing of a single record with a slow memory
        lat = 2;
        n0 = cap_addr.size();
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 16'h1234;
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R4", "mem_req one edge after accept", 128'(mem_req), 0);
        chk("R11", "ready low with holding stage full", 128'(msg_ready), 0);
        @(negedge clk);
        chk("R4", "mem_req two edges after accept", 128'(mem_req), 1);
        chk("R3", "record address", 128'(mem_addr), 128'(BASE));
        chk("R3", "record data", mem_data, 128'h1234);
        chk("R11", "ready back once holding stage drained", 128'(msg_ready), 1);
        @(negedge clk);
        chk("R4", "mem_req held while not granted", 128'(mem_req), 1);
        chk("R4", "address held while not granted", 128'(mem_addr), 128'(BASE));
        drain();
        chk("R4", "one record logged", 128'(cap_addr.size() - n0), 1);
        rd_reg(3'd6, v); chk("R5", "write offset after one record", 128'(v), 128'h10);
        chk("R7", "irq with unread record", 128'(irq), 1);
        wr_reg(3'd5, 32'h10);
        #1 chk("R7", "irq after acknowledge", 128'(irq), 0);

        // R5: full ring sweeps, size codes 0 and 1, full detection off
        wr_reg(3'd0, 32'h0000_0009);
        sweep(2047, 18'h10, 0);
        rd_reg(3'd6, v); chk("R5", "wrap at 32 KB", 128'(v), 0);
        chk("R7", "irq with offsets apart", 128'(irq), 1);
        wr_reg(3'd0, 32'h0000_0109);
        sweep(4096, 18'h0, 1);
        rd_reg(3'd6, v); chk("R5", "wrap at 64 KB", 128'(v), 0);

        // R6: read offset masking for every size code
        for (int c = 0; c < 4; c++) begin
            wr_reg(3'd0, 32'h0000_0009 | (32'(c) << 8));
            wr_reg(3'd5, 32'hFFFF_FFFF);
            rd_reg(3'd5, v); chk("R6", "read offset mask", 128'(v), 128'(mask_of(c)));
            wr_reg(3'd5, 32'h0000_1237);
            rd_reg(3'd5, v); chk("R6", "read offset align", 128'(v), 128'h1230);
        end
        chk("R7", "irq follows offsets", 128'(irq), 1);
        wr_reg(3'd0, 32'h0000_0001);
        #1 chk("R7", "irq masked by enable bit", 128'(irq), 0);

        // R8: stop-when-full drops and sets sticky overflow
        wr_reg(3'd0, 32'h0000_001B);
        wr_reg(3'd5, 32'h40);
        lat = 1;
        for (int i = 0; i < 3; i++) send(16'(16'hA0 + i));
        drain();
        rd_reg(3'd6, v); chk("R8", "offset when full", 128'(v), 128'h30);
        n0 = cap_addr.size();
        send(16'h00DD);
        drain();
        chk("R8", "no record when dropped", 128'(cap_addr.size() - n0), 0);
        rd_reg(3'd6, v); chk("R8", "offset unchanged by drop", 128'(v), 128'h30);
        rd_reg(3'd0, v); chk("R8", "overflow flag set", 128'(v), 128'h801B);
        wr_reg(3'd0, 32'h0000_001B);
        rd_reg(3'd0, v); chk("R8", "overflow sticky on write-zero", 128'(v), 128'h801B);
        wr_reg(3'd0, 32'h0000_801B);
        rd_reg(3'd0, v); chk("R8", "overflow cleared by write-one", 128'(v), 128'h001B);

        // R9: overwrite policy pushes the read offset
        wr_reg(3'd0, 32'h0000_000B);
        n0 = cap_addr.size();
        send(16'h0BEE);
        drain();
        chk("R9", "overwrite record written", 128'(cap_addr.size() - n0), 1);
        if (cap_addr.size() > n0)
            chk("R9", "overwrite address", 128'(cap_addr[n0]), 128'(BASE + 64'h30));
        rd_reg(3'd6, v); chk("R9", "write offset after overwrite", 128'(v), 128'h40);
        rd_reg(3'd5, v); chk("R9", "read offset pushed", 128'(v), 128'h50);
        rd_reg(3'd0, v); chk("R9", "no overflow on overwrite", 128'(v), 128'h000B);
        wr_reg(3'd0, 32'h0000_0009);
        send(16'h0C0D);
        drain();
        rd_reg(3'd5, v); chk("R9", "read offset kept without full detection", 128'(v), 128'h50);
        rd_reg(3'd6, v); chk("R9", "write offset without full detection", 128'(v), 128'h50);

        // R10: disabled unit swallows messages
        wr_reg(3'd0, 32'h0000_0008);
        n0 = cap_addr.size();
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 16'h0E0E;
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R10", "ready stays high when disabled", 128'(msg_ready), 1);
        drain();
        chk("R10", "no record when disabled", 128'(cap_addr.size() - n0), 0);
        rd_reg(3'd6, v); chk("R10", "offset unchanged when disabled", 128'(v), 128'h50);

        // R11: back-pressure with a slow memory
        wr_reg(3'd0, 32'h0000_0009);
        lat = 6;
        n0 = cap_addr.size();
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 16'h00AA;
        @(negedge clk);
        chk("R11", "ready low after first accept", 128'(msg_ready), 0);
        msg_data = 16'h00BB;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R11", "second message held", 128'(msg_ready), 0);
        chk("R11", "first write outstanding", 128'(mem_req), 1);
        repeat (2) @(negedge clk);
        chk("R11", "still stalled behind slow write", 128'(msg_ready), 0);
        repeat (40) @(negedge clk);
        chk("R11", "both records written", 128'(cap_addr.size() - n0), 2);
        if (cap_addr.size() >= n0 + 2) begin
            chk("R11", "order first", cap_data[n0], 128'h00AA);
            chk("R11", "order second", cap_data[n0 + 1], 128'h00BB);
            chk("R5", "second address", 128'(cap_addr[n0 + 1]), 128'(BASE + 64'h60));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule